// File: doc/BRIEF.md
# Multiprocessor-Mode Serial Receive Filter

This block is an asynchronous serial receiver with an optional addressed-frame format. When that format is on, each character carries one extra bit after its eight data bits. A value of 1 in that bit marks the character as a station ID. A value of 0 marks it as ordinary data. A station that is not being addressed can arm a wait-for-ID switch. While the switch is armed, every data character is discarded silently: no data transfer, no flag change and no interrupt. The first ID character that arrives is accepted as usual, and the hardware disarms the switch itself, so the characters that follow are received normally.

The line is sampled on a strobe that pulses once per oversampling interval, 16 times per bit by default. The receiver finds the falling edge of a start bit, checks that the start bit is still low at mid-bit, and samples each following bit at its centre. Accepted characters go into a data register and set a small set of status flags. Each flag has its own clear input. Two interrupt outputs come from these flags: one for received data and one for receive errors.

Top module: `mp_rx_filter`

## Requirements
- R1: After reset, rx_data is 0, the flags ready, ferr, ovr and mp_flag are 0, wait_id is 0, and both interrupt outputs are 0.
- R2: A character is a low start bit, then 8 data bits with the LSB first, then the ID bit (only when mp_mode=1), then a stop bit. If ready is 0 when the character is accepted, its data goes into rx_data and ready is set.
- R3: A stop bit that is sampled low sets ferr. The data is still transferred as in R2.
- R4: If an accepted character completes while ready is 1, ovr is set and rx_data keeps its previous value.
- R5: While the filter is active, a character whose ID bit is 0 is discarded. The filter is active when wait_id=1, mp_mode=1 and sync_mode=0. A discarded character leaves rx_data, ready, ferr, ovr and mp_flag unchanged, even if its stop bit is low.
- R6: While the filter is active, a character whose ID bit is 1 is accepted as in R2 to R4. It sets mp_flag to 1 and clears wait_id to 0.
- R7: When sync_mode=1 or mp_mode=0, wait_id has no effect. Every character is accepted, and wait_id keeps its value.
- R8: rx_irq = ready AND rx_int_en. err_irq = (ferr OR ovr) AND err_int_en. Both outputs are forced to 0 while the filter is active.
- R9: A one-cycle pulse on wait_wr loads wait_wdata into wait_id. Software can clear the switch this way. A pulse on clr_ready, clr_ferr or clr_ovr clears the matching flag.
- R10: A low pulse on rxd shorter than half a bit period, starting from an idle line, does not produce a character and changes no output.
- R11: Every accepted character updates mp_flag: to the received ID bit in mp_mode, and to 0 when mp_mode=0. An accepted data character therefore clears mp_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| os_tick | input | 1 | Oversampling strobe, one cycle wide, OSR pulses per bit |
| rxd | input | 1 | Serial receive line, idle high |
| mp_mode | input | 1 | 1 selects characters that carry an ID bit |
| sync_mode | input | 1 | 1 selects synchronous mode, which makes wait_id inert |
| wait_wr | input | 1 | Write strobe for wait_id |
| wait_wdata | input | 1 | Value written into wait_id |
| clr_ready | input | 1 | Clears ready |
| clr_ferr | input | 1 | Clears ferr |
| clr_ovr | input | 1 | Clears ovr |
| rx_int_en | input | 1 | Enables the receive interrupt |
| err_int_en | input | 1 | Enables the receive-error interrupt |
| rx_data | output | DATA_BITS | Last transferred character |
| ready | output | 1 | Data-ready flag |
| ferr | output | 1 | Framing-error flag |
| ovr | output | 1 | Overrun flag |
| mp_flag | output | 1 | ID bit of the last accepted character |
| wait_id | output | 1 | Wait-for-ID switch |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Receive-error interrupt |

## Verification
The hardest case to reach is a discarded data character that arrives while ready is already set and its own stop bit is low. If the filter failed, that character would leave a visible trace in both ovr and ferr. The directed part of the stimulus first sets ready with a normal character, then arms wait_id and sends a bad-stop data character. After that it sends an ID character, which must set ovr, mp_flag and clear wait_id. The random part mixes the mode bits, the ID bit, stop-bit errors and software writes, so that both discards and hardware disarms happen under many different flag states.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_BITS  = 2'd2
  } rx_state_e;

  typedef struct packed {
    logic ready;
    logic ferr;
    logic ovr;
    logic mpf;
  } rx_flags_t;

  // number of sampled bits that follow the start bit
  function automatic int unsigned bits_after_start(int unsigned data_bits, logic mp);
    return data_bits + 1 + (mp ? 1 : 0);
  endfunction
endpackage

// File: rtl/mpf_sampler.sv
module mpf_sampler
  import mpf_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 os_tick,
  input  logic                 rxd_in,
  input  logic                 mp_mode,
  output logic                 frame_done,
  output logic [DATA_BITS-1:0] frame_data,
  output logic                 frame_mpb,
  output logic                 frame_stop_ok
);
  localparam int unsigned HALF = OSR / 2;
  localparam int unsigned CW   = $clog2(OSR);
  localparam int unsigned NB   = DATA_BITS + 2;
  localparam int unsigned IW   = $clog2(NB + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rxd_s;
  rx_state_e              state;
  logic [CW-1:0]          cnt;
  logic [IW-1:0]          idx;
  logic [NB-1:0]          bits_q, bits_nx;
  logic                   mp_lat, prev;
  logic                   last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_in};
  end
  assign rxd_s = sync_q[SYNC_STAGES-1];

  assign last_bit = (int'(idx) == int'(bits_after_start(DATA_BITS, mp_lat)) - 1);

  always_comb begin
    bits_nx      = bits_q;
    bits_nx[idx] = rxd_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= RX_IDLE;
      cnt           <= '0;
      idx           <= '0;
      bits_q        <= '0;
      mp_lat        <= 1'b0;
      prev          <= 1'b1;
      frame_done    <= 1'b0;
      frame_data    <= '0;
      frame_mpb     <= 1'b0;
      frame_stop_ok <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      if (os_tick) begin
        unique case (state)
          RX_IDLE: begin
            prev <= rxd_s;
            if (prev && !rxd_s) begin
              state  <= RX_START;
              cnt    <= '0;
              mp_lat <= mp_mode;
            end
          end
          RX_START: begin
            if (cnt == CW'(HALF - 1)) begin
              if (rxd_s) begin
                state <= RX_IDLE;
                prev  <= 1'b1;
              end else begin
                state <= RX_BITS;
                cnt   <= '0;
                idx   <= '0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_BITS: begin
            if (cnt == CW'(OSR - 1)) begin
              cnt    <= '0;
              bits_q <= bits_nx;
              idx    <= idx + 1'b1;
              if (last_bit) begin
                frame_done    <= 1'b1;
                frame_data    <= bits_nx[DATA_BITS-1:0];
                frame_mpb     <= mp_lat ? bits_nx[DATA_BITS] : 1'b0;
                frame_stop_ok <= mp_lat ? bits_nx[DATA_BITS+1] : bits_nx[DATA_BITS];
                state         <= RX_IDLE;
                prev          <= rxd_s;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mpf_status.sv
module mpf_status
  import mpf_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_done,
  input  logic [DATA_BITS-1:0] frame_data,
  input  logic                 frame_mpb,
  input  logic                 frame_stop_ok,
  input  logic                 filter_on,
  input  logic                 wait_wr,
  input  logic                 wait_wdata,
  input  logic                 clr_ready,
  input  logic                 clr_ferr,
  input  logic                 clr_ovr,
  output logic [DATA_BITS-1:0] rx_data,
  output rx_flags_t            flags,
  output logic                 wait_id,
  output logic                 filter_active,
  output logic                 frame_accept,
  output logic                 frame_drop
);
  logic id_hit;

  assign filter_active = wait_id & filter_on;
  assign frame_drop    = frame_done & filter_active & ~frame_mpb;
  assign frame_accept  = frame_done & ~frame_drop;
  assign id_hit        = frame_accept & filter_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
      flags   <= '0;
    end else begin
      if (clr_ready) flags.ready <= 1'b0;
      if (clr_ferr)  flags.ferr  <= 1'b0;
      if (clr_ovr)   flags.ovr   <= 1'b0;
      if (frame_accept) begin
        flags.mpf <= frame_mpb;
        if (!frame_stop_ok) flags.ferr <= 1'b1;
        if (flags.ready) begin
          flags.ovr <= 1'b1;
        end else begin
          rx_data     <= frame_data;
          flags.ready <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wait_id <= 1'b0;
    else if (wait_wr) wait_id <= wait_wdata;
    else if (id_hit)  wait_id <= 1'b0;
  end
endmodule

// File: rtl/mp_rx_filter.sv
module mp_rx_filter
  import mpf_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned DATA_BITS   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 os_tick,
  input  logic                 rxd,
  input  logic                 mp_mode,
  input  logic                 sync_mode,
  input  logic                 wait_wr,
  input  logic                 wait_wdata,
  input  logic                 clr_ready,
  input  logic                 clr_ferr,
  input  logic                 clr_ovr,
  input  logic                 rx_int_en,
  input  logic                 err_int_en,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 ready,
  output logic                 ferr,
  output logic                 ovr,
  output logic                 mp_flag,
  output logic                 wait_id,
  output logic                 rx_irq,
  output logic                 err_irq
);
  logic                 frame_done, frame_mpb, frame_stop_ok;
  logic [DATA_BITS-1:0] frame_data;
  logic                 filter_on, filter_active, frame_accept, frame_drop;
  rx_flags_t            flags;

  function automatic logic irq_gate(logic src, logic en, logic masked);
    return src & en & ~masked;
  endfunction

  assign filter_on = mp_mode & ~sync_mode;

  mpf_sampler #(.OSR(OSR), .DATA_BITS(DATA_BITS), .SYNC_STAGES(SYNC_STAGES)) sampler_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd_in(rxd), .mp_mode(mp_mode),
    .frame_done(frame_done), .frame_data(frame_data), .frame_mpb(frame_mpb),
    .frame_stop_ok(frame_stop_ok)
  );

  mpf_status #(.DATA_BITS(DATA_BITS)) status_i (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_data(frame_data),
    .frame_mpb(frame_mpb), .frame_stop_ok(frame_stop_ok), .filter_on(filter_on),
    .wait_wr(wait_wr), .wait_wdata(wait_wdata), .clr_ready(clr_ready),
    .clr_ferr(clr_ferr), .clr_ovr(clr_ovr), .rx_data(rx_data), .flags(flags),
    .wait_id(wait_id), .filter_active(filter_active), .frame_accept(frame_accept),
    .frame_drop(frame_drop)
  );

  assign ready   = flags.ready;
  assign ferr    = flags.ferr;
  assign ovr     = flags.ovr;
  assign mp_flag = flags.mpf;
  assign rx_irq  = irq_gate(flags.ready, rx_int_en, filter_active);
  assign err_irq = irq_gate(flags.ferr | flags.ovr, err_int_en, filter_active);
endmodule

// File: rtl/mpf_checker.sv
module mpf_checker #(
  parameter int unsigned DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_done,
  input logic                 frame_accept,
  input logic                 frame_drop,
  input logic                 filter_on,
  input logic                 filter_active,
  input logic                 wait_wr,
  input logic                 clr_ready,
  input logic                 clr_ferr,
  input logic                 clr_ovr,
  input logic                 rx_int_en,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 ready,
  input logic                 ferr,
  input logic                 ovr,
  input logic                 mp_flag,
  input logic                 wait_id,
  input logic                 rx_irq,
  input logic                 err_irq
);
  // R2
  ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(frame_accept));

  // R4
  overrun_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept && ready && !clr_ready |=> ovr && $stable(rx_data));

  // R5
  drop_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop && !clr_ready && !clr_ferr && !clr_ovr |=>
      $stable(rx_data) && $stable(ready) && $stable(ferr) && $stable(ovr) && $stable(mp_flag));

  // R6
  id_clears_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_accept && filter_active && !wait_wr |=> !wait_id && mp_flag);

  // R7
  wait_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !filter_on && !wait_wr |=> wait_id == $past(wait_id));

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filter_active |-> !rx_irq && !err_irq);

  // R8
  rx_irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_int_en |-> !rx_irq);
endmodule

bind mp_rx_filter mpf_checker #(.DATA_BITS(DATA_BITS)) checker_i (
  .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .frame_accept(frame_accept),
  .frame_drop(frame_drop), .filter_on(filter_on), .filter_active(filter_active),
  .wait_wr(wait_wr), .clr_ready(clr_ready), .clr_ferr(clr_ferr), .clr_ovr(clr_ovr),
  .rx_int_en(rx_int_en), .rx_data(rx_data), .ready(ready), .ferr(ferr), .ovr(ovr),
  .mp_flag(mp_flag), .wait_id(wait_id), .rx_irq(rx_irq), .err_irq(err_irq)
);

// File: tb/mp_rx_filter_tb_top.sv
module mp_rx_filter_tb_top;
  localparam int OSR = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick = 1'b0;
  logic rxd = 1'b1;
  logic mp_mode = 1'b0, sync_mode = 1'b0;
  logic wait_wr = 1'b0, wait_wdata = 1'b0;
  logic clr_ready = 1'b0, clr_ferr = 1'b0, clr_ovr = 1'b0;
  logic rx_int_en = 1'b0, err_int_en = 1'b0;
  logic [7:0] rx_data;
  logic ready, ferr, ovr, mp_flag, wait_id, rx_irq, err_irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [1:0] tdiv = '0;

  logic [7:0] m_data;
  logic m_ready, m_ferr, m_ovr, m_mpf, m_wait;

  mp_rx_filter dut_i (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .mp_mode(mp_mode),
    .sync_mode(sync_mode), .wait_wr(wait_wr), .wait_wdata(wait_wdata),
    .clr_ready(clr_ready), .clr_ferr(clr_ferr), .clr_ovr(clr_ovr),
    .rx_int_en(rx_int_en), .err_int_en(err_int_en), .rx_data(rx_data),
    .ready(ready), .ferr(ferr), .ovr(ovr), .mp_flag(mp_flag), .wait_id(wait_id),
    .rx_irq(rx_irq), .err_irq(err_irq)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    tdiv    <= tdiv + 2'd1;
    os_tick <= (tdiv == 2'd3);
  end

  function automatic logic filt_exp(logic w, logic mp, logic sy);
    return w & mp & ~sy;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic f;
    logic exp_rx, exp_err;
    @(negedge clk);
    f = filt_exp(m_wait, mp_mode, sync_mode);
    exp_rx  = m_ready & rx_int_en & ~f;
    exp_err = (m_ferr | m_ovr) & err_int_en & ~f;
    chk(rx_data == m_data, {tag, " rx_data"}, rx_data, m_data);
    chk(ready == m_ready, {tag, " ready"}, ready, m_ready);
    chk(ferr == m_ferr, {tag, " ferr"}, ferr, m_ferr);
    chk(ovr == m_ovr, {tag, " ovr"}, ovr, m_ovr);
    chk(mp_flag == m_mpf, {tag, " mp_flag"}, mp_flag, m_mpf);
    chk(wait_id == m_wait, {tag, " wait_id"}, wait_id, m_wait);
    chk(rx_irq == exp_rx, {tag, " rx_irq R8"}, rx_irq, exp_rx);
    chk(err_irq == exp_err, {tag, " err_irq R8"}, err_irq, exp_err);
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) @(posedge clk iff os_tick);
  endtask

  task automatic send_bit(input logic b);
    rxd <= b;
    wait_ticks(OSR);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic mpb, input logic stop_ok);
    logic f;
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (mp_mode) send_bit(mpb);
    send_bit(stop_ok);
    send_bit(1'b1);
    send_bit(1'b1);
    f = filt_exp(m_wait, mp_mode, sync_mode);
    if (!(f && !mpb)) begin
      m_mpf = mp_mode ? mpb : 1'b0;
      if (f) m_wait = 1'b0;
      if (!stop_ok) m_ferr = 1'b1;
      if (m_ready) m_ovr = 1'b1;
      else begin
        m_data  = d;
        m_ready = 1'b1;
      end
    end
  endtask

  task automatic write_wait(input logic v);
    @(negedge clk);
    wait_wr = 1'b1; wait_wdata = v;
    @(negedge clk);
    wait_wr = 1'b0;
    m_wait = v;
  endtask

  task automatic clear_flags(input logic r, input logic fe, input logic ov);
    @(negedge clk);
    clr_ready = r; clr_ferr = fe; clr_ovr = ov;
    @(negedge clk);
    clr_ready = 1'b0; clr_ferr = 1'b0; clr_ovr = 1'b0;
    if (r) m_ready = 1'b0;
    if (fe) m_ferr = 1'b0;
    if (ov) m_ovr = 1'b0;
  endtask

  initial begin
    #1_400_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_data = '0; m_ready = 0; m_ferr = 0; m_ovr = 0; m_mpf = 0; m_wait = 0;
    repeat (5) @(posedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    wait_ticks(40);

    // R2 plain character, mp_mode off, receive interrupt enabled
    rx_int_en = 1'b1; err_int_en = 1'b1;
    send_frame(8'hA5, 1'b0, 1'b1);
    check_all("R2 normal");

    // R3 low stop bit
    clear_flags(1, 0, 0);
    send_frame(8'h3C, 1'b0, 1'b0);
    check_all("R3 framing");

    // R4 overrun keeps old data
    clear_flags(0, 1, 0);
    send_frame(8'h5A, 1'b0, 1'b1);
    check_all("R4 overrun");

    // R11 accepted data character in mp mode clears mp_flag
    clear_flags(1, 1, 1);
    mp_mode = 1'b1;
    send_frame(8'h81, 1'b1, 1'b1);
    check_all("R11 id first");
    clear_flags(1, 0, 0);
    send_frame(8'h42, 1'b0, 1'b1);
    check_all("R11 data clears mp_flag");

    // R8 armed filter masks interrupts while ready stays set
    write_wait(1'b1);
    check_all("R8 masked");

    // R5 discarded data character with low stop and ready set
    send_frame(8'hEE, 1'b0, 1'b0);
    check_all("R5 drop");

    // R6 ID character disarms, sets mp_flag, overruns
    send_frame(8'h17, 1'b1, 1'b1);
    check_all("R6 id hit");

    // R7 sync mode makes wait_id inert
    clear_flags(1, 1, 1);
    write_wait(1'b1);
    sync_mode = 1'b1;
    send_frame(8'h99, 1'b0, 1'b1);
    check_all("R7 sync inert");
    clear_flags(1, 0, 0);
    sync_mode = 1'b0; mp_mode = 1'b0;
    send_frame(8'h66, 1'b0, 1'b1);
    check_all("R7 mp off inert");

    // R9 software clears wait_id
    mp_mode = 1'b1;
    write_wait(1'b0);
    check_all("R9 soft clear");
    clear_flags(1, 0, 0);
    check_all("R9 flag clear");

    // R10 short low glitch
    rxd <= 1'b0;
    wait_ticks(4);
    rxd <= 1'b1;
    wait_ticks(3 * OSR);
    check_all("R10 glitch");

    for (int n = 0; n < 30; n++) begin
      logic [7:0] d;
      logic mpb, sok;
      d = 8'($urandom);
      mpb = ($urandom % 3) == 0;
      sok = ($urandom % 8) != 0;
      mp_mode = ($urandom % 4) != 0;
      sync_mode = ($urandom % 5) == 0;
      rx_int_en = 1'($urandom);
      err_int_en = 1'($urandom);
      if (($urandom % 3) == 0) write_wait(1'($urandom));
      if (($urandom % 2) == 0) clear_flags(1'($urandom), 1'($urandom), 1'($urandom));
      send_frame(d, mpb, sok);
      check_all("RND R5 R6 R7");
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule